// File: doc/BRIEF.md
# Factory Bad-Block Scanner

After reset, this engine walks every erase block of a NAND array and records which blocks carry a factory bad-block mark. The result is a one-bit-per-block bitmap, where 1 means bad. The engine reads one byte at a time through a request/response port. A request carries a block, a page and a column, and the response returns one byte. The marker byte is the first spare-area byte of a page. Its column equals the main-area size: 8192 by default, in a 256-page block.

For each block, the engine reads the marker on page 0. Only if that byte is FFh does it also read the marker on the last page. A value other than FFh on either page marks the block bad. Blocks are scanned in ascending order from block 0.

When the scan finishes, the engine raises a done flag. It also presents:
- a bad-block count;
- an error flag, set when the count exceeds the allowed maximum of 50;
- a combinational bitmap read port for the system's block allocator.

A start pulse given after completion clears the results and runs the scan again.

Top module: `bbs_top`

## Requirements
- R1: While reset is held, `reqValid`, `scanDone` and `badCount` are 0 and every bitmap bit reads 0. After reset is released, a scan begins without any start pulse.
- R2: A request stays asserted with stable `reqBlock`/`reqPage` until `reqReady` is seen. After acceptance, `reqValid` stays low until a response arrives, so at most one read is outstanding.
- R3: If the page-0 marker of a block is not FFh, the block's bitmap bit becomes 1 and no last-page read is issued for that block.
- R4: If the page-0 marker is FFh, the next request is the same block at page `PAGES_PER_BLOCK-1`. A non-FFh byte there marks the block bad.
- R5: A block whose markers on both pages read FFh keeps bitmap bit 0.
- R6: Every request uses column `MAIN_BYTES` (the first spare byte). Blocks are requested in ascending order from 0, and page 0 always comes before the last page.
- R7: `badCount` equals the number of bad blocks found. `tooManyBad` is 1 exactly when `badCount` exceeds `MAX_BAD` (default 50).
- R8: `scanDone` rises on the second clock edge after the response that decides the last block is presented, that is, one cycle after that result is recorded.
- R9: A `start` pulse while done clears the bitmap, the count, the flag and `scanDone`, then rescans. A `start` pulse during a scan is ignored.
- R10: `mapBad` shows the bitmap bit selected by `mapAddr`, in the same cycle.
- R11: `rspValid` with no read outstanding changes neither the bitmap nor the count.
- R12: Once `scanDone` is high, no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Re-run pulse, honoured only when done |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | Read request accepted |
| reqBlock | output | BLK_W | Block of the read |
| reqPage | output | PG_W | Page of the read |
| reqCol | output | COL_W | Column of the read |
| rspValid | input | 1 | Response byte valid |
| rspByte | input | 8 | Returned marker byte |
| mapAddr | input | BLK_W | Bitmap read address |
| mapBad | output | 1 | Bitmap bit at `mapAddr` |
| badCount | output | CNT_W | Number of bad blocks found |
| tooManyBad | output | 1 | Count exceeds `MAX_BAD` |
| scanDone | output | 1 | Scan complete |

## Verification
The hardest situations to reach are:
- the final block, where the deciding response can come from either page 0 or the last page and sets the exact cycle of `scanDone`;
- a start pulse that lands in the middle of a scan.

The bench uses a small array and a responder model that derives each byte from per-scenario masks of failing page-0 and last-page markers. The scenarios are chosen so that:
- the last block fails on page 0 in one scan and on the last page in another;
- the count lands exactly on the threshold and one past it.

The mid-scan start is fired when the port shows block 10 being requested. The responder checks the request order, so any restart shows up as an out-of-order request.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  typedef enum logic [2:0] {
    S_START,
    S_ISSUE,
    S_WAIT,
    S_FIN,
    S_IDLE
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic markBad;
    logic toLastPage;
    logic nextBlock;
  } scanCtl_t;

endpackage

// File: rtl/bbs_ctrl.sv
module bbs_ctrl
  import bbs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     reqReady,
  input  logic     rspValid,
  input  logic     markerOk,
  input  logic     onFirstPage,
  input  logic     lastBlock,
  output scanCtl_t ctl,
  output logic     reqValid,
  output logic     scanDone
);

  scanState_t state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_START: begin
        ctl.clearAll = 1'b1;
        nextState    = S_ISSUE;
      end
      S_ISSUE: if (reqReady) nextState = S_WAIT;
      S_WAIT: if (rspValid) begin
        if (!markerOk) ctl.markBad = 1'b1;
        if (markerOk && onFirstPage) begin
          ctl.toLastPage = 1'b1;
          nextState      = S_ISSUE;
        end else if (lastBlock) begin
          nextState = S_FIN;
        end else begin
          ctl.nextBlock = 1'b1;
          nextState     = S_ISSUE;
        end
      end
      S_FIN:   nextState = S_IDLE;
      S_IDLE:  if (start) nextState = S_START;
      default: nextState = S_IDLE;
    endcase
  end

  assign reqValid = (state == S_ISSUE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_START;
      scanDone <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_FIN) scanDone <= 1'b1;
      else if (state == S_IDLE && start) scanDone <= 1'b0;
    end
  end

  // R2: only one read in flight
  p_one_out_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqValid);

  // R12: quiet once done
  p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> !reqValid);

  // R8: done follows the deciding response by one recorded cycle
  p_done_follows_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scanDone) |-> $past(rspValid, 2));

endmodule

// File: rtl/bbs_datapath.sv
module bbs_datapath
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 256,
  parameter int MAIN_BYTES      = 8192,
  parameter int SPARE_BYTES     = 448,
  parameter int MAX_BAD         = 50,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int COL_W = $clog2(MAIN_BYTES + SPARE_BYTES),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanCtl_t         ctl,
  input  logic [7:0]       rspByte,
  input  logic [BLK_W-1:0] mapAddr,
  output logic [BLK_W-1:0] reqBlock,
  output logic [PG_W-1:0]  reqPage,
  output logic [COL_W-1:0] reqCol,
  output logic             markerOk,
  output logic             onFirstPage,
  output logic             lastBlock,
  output logic             mapBad,
  output logic [CNT_W-1:0] badCount,
  output logic             tooManyBad
);

  localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [PG_W-1:0]  LAST_PG   = PG_W'(PAGES_PER_BLOCK - 1);
  localparam logic [COL_W-1:0] MARK_COL  = COL_W'(MAIN_BYTES);
  localparam logic [CNT_W-1:0] LIMIT_CNT = CNT_W'(MAX_BAD);
  localparam logic [7:0]       ERASED    = 8'hFF;

  logic [BLK_W-1:0]      blockIdx;
  logic [PG_W-1:0]       pageIdx;
  logic [NUM_BLOCKS-1:0] bitmap;

  assign reqBlock    = blockIdx;
  assign reqPage     = pageIdx;
  assign reqCol      = MARK_COL;
  assign markerOk    = (rspByte == ERASED);
  assign onFirstPage = (pageIdx == '0);
  assign lastBlock   = (blockIdx == LAST_BLK);
  assign mapBad      = bitmap[mapAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockIdx   <= '0;
      pageIdx    <= '0;
      bitmap     <= '0;
      badCount   <= '0;
      tooManyBad <= 1'b0;
    end else if (ctl.clearAll) begin
      blockIdx   <= '0;
      pageIdx    <= '0;
      bitmap     <= '0;
      badCount   <= '0;
      tooManyBad <= 1'b0;
    end else begin
      if (ctl.markBad) begin
        bitmap[blockIdx] <= 1'b1;
        badCount         <= badCount + CNT_W'(1);
        if (badCount == LIMIT_CNT) tooManyBad <= 1'b1;
      end
      if (ctl.toLastPage) pageIdx <= LAST_PG;
      if (ctl.nextBlock) begin
        blockIdx <= blockIdx + BLK_W'(1);
        pageIdx  <= '0;
      end
    end
  end

  // R7: count only climbs by one, or clears
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (badCount != $past(badCount)) |->
      (badCount == $past(badCount) + CNT_W'(1)) || (badCount == '0));

  // R7: error flag implies the count is past the limit
  p_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    tooManyBad |-> (badCount > LIMIT_CNT));

  // R3: a new bad block needs a mark strobe from control
  p_bad_needs_mark_r3: assert property (@(posedge clk) disable iff (!rstN)
    (badCount == $past(badCount) + CNT_W'(1)) |-> $past(ctl.markBad));

endmodule

// File: rtl/bbs_top.sv
module bbs_top
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 256,
  parameter int MAIN_BYTES      = 8192,
  parameter int SPARE_BYTES     = 448,
  parameter int MAX_BAD         = 50,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int COL_W = $clog2(MAIN_BYTES + SPARE_BYTES),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             reqValid,
  input  logic             reqReady,
  output logic [BLK_W-1:0] reqBlock,
  output logic [PG_W-1:0]  reqPage,
  output logic [COL_W-1:0] reqCol,
  input  logic             rspValid,
  input  logic [7:0]       rspByte,
  input  logic [BLK_W-1:0] mapAddr,
  output logic             mapBad,
  output logic [CNT_W-1:0] badCount,
  output logic             tooManyBad,
  output logic             scanDone
);

  scanCtl_t ctl;
  logic     markerOk, onFirstPage, lastBlock;

  bbs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reqReady(reqReady),
    .rspValid(rspValid), .markerOk(markerOk), .onFirstPage(onFirstPage),
    .lastBlock(lastBlock), .ctl(ctl), .reqValid(reqValid), .scanDone(scanDone)
  );

  bbs_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES), .MAX_BAD(MAX_BAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rspByte(rspByte), .mapAddr(mapAddr),
    .reqBlock(reqBlock), .reqPage(reqPage), .reqCol(reqCol),
    .markerOk(markerOk), .onFirstPage(onFirstPage), .lastBlock(lastBlock),
    .mapBad(mapBad), .badCount(badCount), .tooManyBad(tooManyBad)
  );

  // R2: a pending request holds its address
  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqBlock) && $stable(reqPage));

endmodule

// File: tb/sim_bbs_top.sv
`timescale 1ns/10ps
module sim_bbs_top;
  localparam int NB = 64, PPB = 256, MB = 8192, SB = 448, MAXB = 5;
  localparam int BW = $clog2(NB), PGW = $clog2(PPB), COLW = $clog2(MB + SB), CW = $clog2(NB + 1);
  localparam int NV = 4;
  // per scenario: failing page-0 markers, failing last-page markers
  localparam logic [63:0] M0_TAB [NV] = '{64'h0, 64'h8000_0000_0002_0008,
                                          64'h0000_0002_0010_0080, 64'h4000_0000_0000_0000};
  localparam logic [63:0] M1_TAB [NV] = '{64'h0, 64'h0000_0100_0002_0020,
                                          64'h0004_0000_0020_0100, 64'h8000_0000_0000_0000};

  logic clk = 1'b0;
  logic rstN, start, reqReady, rspValid, reqValid, mapBad, tooManyBad, scanDone;
  logic [7:0] rspByte;
  logic [BW-1:0] reqBlock, mapAddr;
  logic [PGW-1:0] reqPage;
  logic [COLW-1:0] reqCol;
  logic [CW-1:0] badCount;

  always #2.5 clk = ~clk;

  bbs_top #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .MAIN_BYTES(MB),
            .SPARE_BYTES(SB), .MAX_BAD(MAXB)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .reqValid(reqValid), .reqReady(reqReady),
    .reqBlock(reqBlock), .reqPage(reqPage), .reqCol(reqCol), .rspValid(rspValid),
    .rspByte(rspByte), .mapAddr(mapAddr), .mapBad(mapBad), .badCount(badCount),
    .tooManyBad(tooManyBad), .scanDone(scanDone));

  int checks = 0, failures = 0;
  int expBlock = 0, expPage = 0, orderErr = 0, holdErr = 0, reqCount = 0;
  logic [63:0] m0, m1;
  bit finished = 0;

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sweep(output logic [NB-1:0] got);
    for (int i = 0; i < NB; i++) begin
      mapAddr = BW'(i);
      #0.01;
      got[i] = mapBad;
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // responder model
  initial begin
    int blk, pg;
    bit bad, last;
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && reqValid) begin
        blk = int'(reqBlock);
        pg  = int'(reqPage);
        if (blk != expBlock || pg != expPage || int'(reqCol) != MB) orderErr++;
        reqCount++;
        for (int k = 0; k < blk % 3; k++) begin
          @(negedge clk);
          if (!reqValid || int'(reqBlock) != blk || int'(reqPage) != pg) holdErr++;
        end
        reqReady = 1'b1;
        @(negedge clk);
        reqReady = 1'b0;
        if (reqValid) holdErr++;
        repeat (1 + blk % 2) begin
          @(negedge clk);
          if (reqValid) holdErr++;
        end
        bad  = (pg == 0) ? m0[blk] : m1[blk];
        last = (blk == NB - 1) && (pg != 0 || bad);
        rspByte  = bad ? (8'hFF ^ (8'h01 << blk[2:0])) : 8'hFF;
        rspValid = 1'b1;
        if (pg == 0 && !bad) expPage = PPB - 1;
        else begin expBlock++; expPage = 0; end
        @(negedge clk);
        rspValid = 1'b0;
        rspByte  = 8'h00;
        if (last) begin
          checkEq("R8 done still low one cycle after final response", int'(scanDone), 0);
          @(negedge clk);
          checkEq("R8 done high two cycles after final response", int'(scanDone), 1);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [NB-1:0] got, expMap, prevMap;
    int expCnt;
    bit pulsed;
    rstN = 1'b0; start = 1'b0; reqReady = 1'b0; rspValid = 1'b0; rspByte = 8'h00;
    mapAddr = '0; m0 = M0_TAB[0]; m1 = M1_TAB[0];
    repeat (4) @(negedge clk);
    checkEq("R1 reset reqValid", int'(reqValid), 0);
    checkEq("R1 reset scanDone", int'(scanDone), 0);
    checkEq("R1 reset badCount", int'(badCount), 0);
    sweep(got);
    checkEq("R1 reset bitmap bits set", $countones(got), 0);
    rstN = 1'b1;
    prevMap = '0;

    for (int v = 0; v < NV; v++) begin
      if (v > 0) begin
        m0 = M0_TAB[v]; m1 = M1_TAB[v];
        expBlock = 0; expPage = 0; orderErr = 0; holdErr = 0; reqCount = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        checkEq("R9 done cleared by start", int'(scanDone), 0);
        @(negedge clk);
        checkEq("R9 count cleared by start", int'(badCount), 0);
        checkEq("R9 flag cleared by start", int'(tooManyBad), 0);
        sweep(got);
        checkEq("R9 bitmap cleared by start", $countones(got & prevMap), 0);
      end
      pulsed = 0;
      while (!scanDone) begin
        @(negedge clk);
        if (v == 2 && !pulsed && reqValid && int'(reqBlock) == 10) begin
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          pulsed = 1;
        end
      end
      expMap = m0 | m1;
      expCnt = $countones(expMap);
      checkEq($sformatf("R7 bad count scenario %0d", v), int'(badCount), expCnt);
      checkEq($sformatf("R7 limit flag scenario %0d", v), int'(tooManyBad), int'(expCnt > MAXB));
      sweep(got);
      checkEq($sformatf("R3 R4 R10 bad bits missing scenario %0d", v), $countones(expMap & ~got), 0);
      checkEq($sformatf("R5 good bits wrongly set scenario %0d", v), $countones(~expMap & got), 0);
      checkEq($sformatf("R1 R6 R9 request order scenario %0d", v), orderErr, 0);
      checkEq($sformatf("R2 hold and single outstanding scenario %0d", v), holdErr, 0);
      checkEq($sformatf("R3 R4 request count scenario %0d", v), reqCount, 2 * NB - $countones(m0));
      repeat (3) @(negedge clk);
      checkEq($sformatf("R12 no request after done scenario %0d", v), int'(reqValid), 0);
      prevMap = got;
    end

    // stray response with nothing outstanding
    rspByte = 8'h00;
    rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0;
    @(negedge clk);
    checkEq("R11 count unchanged by stray response", int'(badCount), $countones(prevMap));
    sweep(got);
    checkEq("R11 bitmap unchanged by stray response", $countones(got ^ prevMap), 0);
    checkEq("R11 still done, no request", int'(scanDone && !reqValid), 1);
    finishRun();
  end
endmodule